// File: doc/BRIEF.md
# Cascaded Second-Level Interrupt Aggregator

This block sits between a set of up to 32 level-sensitive interrupt sources and a parent interrupt controller. It has several grouped parent outputs. Each one is the OR of a configurable subset of the lines, taken after per-line enable masking. Which lines feed which grouped output is fixed by one 32-bit selection mask per output, given as a parameter. Line positions that are not wired at all never show up anywhere.

A few lines carry a steering mux, and each of these drives its own dedicated parent output. A per-line forward mask, also fixed at build time, sets the mux. With the forward bit set, the raw line goes straight to the dedicated output and the controller ignores it. With the bit clear, the dedicated output is gated by the line's enable bit, and the line also takes part in the status and grouped logic.

Software sees an 8-byte register window. The enable register is at byte offset 0 and the read-only status register is at offset 4. An optional wake request tells the system that an enabled, controller-owned interrupt is active. All outputs are registered and follow the inputs with exactly one clock of latency.

Top module: `l2_irq_aggregator`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every output is 0. The enable register comes out of reset as all zeros.
- R2: A write with `reg_addr_i[2]`=0 loads the enable register. Reading that address returns the enable bits, and bits of unwired line positions always read as 0.
- R3: Reading with `reg_addr_i[2]`=1 returns the status register. This holds the input level sampled one cycle earlier for each wired, non-forwarded line. Writes to this address change nothing.
- R4: Grouped output g is 1 one cycle after any line that is selected by map mask g, is in status, and is enabled.
- R5: Activity on unwired line positions never sets a status bit, a grouped output, a dedicated output or the wake output.
- R6: A muxed line whose forward bit is 1 drives its dedicated output with its raw level one cycle later, whatever its enable bit holds.
- R7: A muxed line whose forward bit is 0 drives its dedicated output with its level ANDed with its enable bit, one cycle later.
- R8: A forwarded line never appears in status, in a grouped output or in the wake output.
- R9: With wake support built in, `wake_o` is 1 one cycle after any enabled status line is active. Without it, `wake_o` stays 0.
- R10: `reg_rdata_o` is loaded on the clock edge where `reg_rd_i` is 1 and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | LINES | Level interrupt inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Byte offset within the register window |
| reg_wdata_i | input | LINES | Write data |
| reg_rdata_o | output | LINES | Registered read data |
| grp_irq_o | output | NUM_GROUP | Grouped outputs to the parent |
| ded_irq_o | output | NUM_MUXED | Dedicated outputs of the muxed lines |
| wake_o | output | 1 | Wake request |

## Verification
The bench builds the block with two grouped outputs, using masks 0xEB8 and 0x140. Lines 0, 1 and 2 are muxed, wake support is on, and the forward mask is 0x3. This mask forwards lines 0 and 1 and keeps line 2 gated. Both mux variants are therefore elaborated side by side. Since positions 12 to 31 are left unwired, the masking of unconnected enable, status and output bits can be observed directly.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;
  localparam int IDX_W = 5;

  // Register selected by the word bit of the byte offset.
  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;

  localparam int SEL_BIT = 2;
endpackage

// File: rtl/l2irq_regs.sv
module l2irq_regs
  import l2irq_pkg::*;
#(
  parameter int          LINES = 32,
  parameter logic [LINES-1:0] CONN = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             rd_i,
  input  reg_sel_e         sel_i,
  input  logic [LINES-1:0] wdata_i,
  input  logic [LINES-1:0] status_i,
  output logic [LINES-1:0] enable_o,
  output logic [LINES-1:0] rdata_o
);
  logic [LINES-1:0] en_q;
  logic [LINES-1:0] rd_mux;

  // Only wired positions can hold an enable bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr_i && (sel_i == SEL_ENABLE)) begin
      en_q <= wdata_i & CONN;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_ENABLE: rd_mux = en_q;
      SEL_STATUS: rd_mux = status_i;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      rdata_o <= rd_mux;
    end
  end

  assign enable_o = en_q;
endmodule

// File: rtl/l2irq_route.sv
module l2irq_route #(
  parameter int                         LINES     = 32,
  parameter int                         NUM_GROUP = 2,
  parameter logic [NUM_GROUP*LINES-1:0] GROUP_MAP = '0,
  parameter bit                         WAKE_EN   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LINES-1:0]     live_i,
  input  logic [LINES-1:0]     enable_i,
  output logic [NUM_GROUP-1:0] grp_o,
  output logic                 wake_o
);
  logic [LINES-1:0] armed;
  assign armed = live_i & enable_i;

  for (genvar g = 0; g < NUM_GROUP; g++) begin : g_grp
    localparam logic [LINES-1:0] MAP = GROUP_MAP[g*LINES +: LINES];
    always_ff @(posedge clk) begin
      if (rst) grp_o[g] <= 1'b0;
      else     grp_o[g] <= |(armed & MAP);
    end
  end

  if (WAKE_EN) begin : g_wake
    always_ff @(posedge clk) begin
      if (rst) wake_o <= 1'b0;
      else     wake_o <= |armed;
    end
  end else begin : g_nowake
    assign wake_o = 1'b0;
  end
endmodule

// File: rtl/l2irq_mux.sv
module l2irq_mux
  import l2irq_pkg::*;
#(
  parameter int                         LINES     = 32,
  parameter int                         NUM_MUXED = 3,
  parameter logic [NUM_MUXED*IDX_W-1:0] MUX_LINES = '0,
  parameter logic [LINES-1:0]           FWD_MASK  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LINES-1:0]     irq_i,
  input  logic [LINES-1:0]     enable_i,
  output logic [NUM_MUXED-1:0] ded_o
);
  for (genvar i = 0; i < NUM_MUXED; i++) begin : g_ded
    localparam int LN = int'(MUX_LINES[i*IDX_W +: IDX_W]);
    logic nxt;
    if (FWD_MASK[LN]) begin : g_bypass
      assign nxt = irq_i[LN];
    end else begin : g_gated
      assign nxt = irq_i[LN] & enable_i[LN];
    end
    always_ff @(posedge clk) begin
      if (rst) ded_o[i] <= 1'b0;
      else     ded_o[i] <= nxt;
    end
  end
endmodule

// File: rtl/l2_irq_aggregator.sv
module l2_irq_aggregator
  import l2irq_pkg::*;
#(
  parameter int                         LINES     = 32,
  parameter int                         NUM_GROUP = 2,
  parameter logic [NUM_GROUP*LINES-1:0] GROUP_MAP = {32'h0000_0140, 32'h0000_0EB8},
  parameter int                         NUM_MUXED = 3,
  parameter logic [NUM_MUXED*IDX_W-1:0] MUX_LINES = {5'd2, 5'd1, 5'd0},
  parameter logic [LINES-1:0]           FWD_MASK  = 32'h0000_0007,
  parameter bit                         WAKE_EN   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LINES-1:0]     irq_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [2:0]           reg_addr_i,
  input  logic [LINES-1:0]     reg_wdata_i,
  output logic [LINES-1:0]     reg_rdata_o,
  output logic [NUM_GROUP-1:0] grp_irq_o,
  output logic [NUM_MUXED-1:0] ded_irq_o,
  output logic                 wake_o
);
  function automatic logic [LINES-1:0] wired_mask();
    logic [LINES-1:0] m = '0;
    for (int g = 0; g < NUM_GROUP; g++) m |= GROUP_MAP[g*LINES +: LINES];
    for (int i = 0; i < NUM_MUXED; i++) m[int'(MUX_LINES[i*IDX_W +: IDX_W])] = 1'b1;
    return m;
  endfunction

  localparam logic [LINES-1:0] CONN = wired_mask();
  localparam logic [LINES-1:0] OWN  = CONN & ~FWD_MASK;

  logic [LINES-1:0] live;
  logic [LINES-1:0] stat_q;
  logic [LINES-1:0] en_w;
  reg_sel_e         sel;

  assign live = irq_i & OWN;
  assign sel  = reg_sel_e'(reg_addr_i[SEL_BIT]);

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= live;
  end

  l2irq_regs #(.LINES(LINES), .CONN(CONN)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .rd_i(reg_rd_i), .sel_i(sel),
    .wdata_i(reg_wdata_i), .status_i(stat_q), .enable_o(en_w), .rdata_o(reg_rdata_o)
  );

  l2irq_route #(.LINES(LINES), .NUM_GROUP(NUM_GROUP), .GROUP_MAP(GROUP_MAP),
                .WAKE_EN(WAKE_EN)) u_route (
    .clk(clk), .rst(rst), .live_i(live), .enable_i(en_w),
    .grp_o(grp_irq_o), .wake_o(wake_o)
  );

  l2irq_mux #(.LINES(LINES), .NUM_MUXED(NUM_MUXED), .MUX_LINES(MUX_LINES),
              .FWD_MASK(FWD_MASK)) u_mux (
    .clk(clk), .rst(rst), .irq_i(irq_i), .enable_i(en_w), .ded_o(ded_irq_o)
  );
endmodule

// File: rtl/l2_irq_aggregator_chk.sv
module l2_irq_aggregator_chk
  import l2irq_pkg::*;
#(
  parameter int                         LINES     = 32,
  parameter int                         NUM_GROUP = 2,
  parameter logic [NUM_GROUP*LINES-1:0] GROUP_MAP = '0,
  parameter int                         NUM_MUXED = 3,
  parameter logic [NUM_MUXED*IDX_W-1:0] MUX_LINES = '0,
  parameter logic [LINES-1:0]           FWD_MASK  = '0,
  parameter bit                         WAKE_EN   = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [LINES-1:0]     irq_i,
  input logic                 reg_rd_i,
  input logic [2:0]           reg_addr_i,
  input logic [LINES-1:0]     reg_rdata_o,
  input logic [NUM_GROUP-1:0] grp_irq_o,
  input logic [NUM_MUXED-1:0] ded_irq_o,
  input logic                 wake_o,
  input logic [LINES-1:0]     en_w
);
  function automatic logic [LINES-1:0] wired();
    logic [LINES-1:0] m = '0;
    for (int g = 0; g < NUM_GROUP; g++) m |= GROUP_MAP[g*LINES +: LINES];
    for (int i = 0; i < NUM_MUXED; i++) m[int'(MUX_LINES[i*IDX_W +: IDX_W])] = 1'b1;
    return m;
  endfunction
  localparam logic [LINES-1:0] CW = wired();

  AST_RST_QUIET: assert property (@(posedge clk) $past(rst) |-> (grp_irq_o == '0 && ded_irq_o == '0 && !wake_o)); // R1
  AST_EN_UNWIRED_ZERO: assert property (@(posedge clk) disable iff (rst) (reg_rd_i && !reg_addr_i[2]) |=> ((reg_rdata_o & ~CW) == '0)); // R2
  AST_STATUS_CLEAN: assert property (@(posedge clk) disable iff (rst) (reg_rd_i && reg_addr_i[2]) |=> ((reg_rdata_o & (~CW | FWD_MASK)) == '0)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) !reg_rd_i |=> $stable(reg_rdata_o)); // R10

  for (genvar g = 0; g < NUM_GROUP; g++) begin : g_grp
    localparam logic [LINES-1:0] M = GROUP_MAP[g*LINES +: LINES] & CW & ~FWD_MASK;
    AST_GRP_FOLLOWS: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (grp_irq_o[g] == $past(|(irq_i & en_w & M)))); // R4
  end

  for (genvar i = 0; i < NUM_MUXED; i++) begin : g_ded
    localparam int LN = int'(MUX_LINES[i*IDX_W +: IDX_W]);
    if (FWD_MASK[LN]) begin : g_f
      AST_DED_RAW: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (ded_irq_o[i] == $past(irq_i[LN]))); // R6
    end else begin : g_n
      AST_DED_GATED: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (ded_irq_o[i] == $past(irq_i[LN] & en_w[LN]))); // R7
    end
  end

  if (WAKE_EN) begin : g_w
    AST_WAKE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (wake_o == $past(|(irq_i & en_w & CW & ~FWD_MASK)))); // R9
  end else begin : g_nw
    AST_WAKE_OFF: assert property (@(posedge clk) !wake_o); // R9
  end
endmodule

bind l2_irq_aggregator l2_irq_aggregator_chk #(
  .LINES(LINES), .NUM_GROUP(NUM_GROUP), .GROUP_MAP(GROUP_MAP), .NUM_MUXED(NUM_MUXED),
  .MUX_LINES(MUX_LINES), .FWD_MASK(FWD_MASK), .WAKE_EN(WAKE_EN)
) u_chk (
  .clk(clk), .rst(rst), .irq_i(irq_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
  .reg_rdata_o(reg_rdata_o), .grp_irq_o(grp_irq_o), .ded_irq_o(ded_irq_o),
  .wake_o(wake_o), .en_w(en_w)
);

// File: tb/tb_l2_irq_aggregator.sv
module tb_l2_irq_aggregator;
  localparam logic [31:0] MAP0 = 32'h0000_0EB8;
  localparam logic [31:0] MAP1 = 32'h0000_0140;
  localparam logic [31:0] FWD  = 32'h0000_0003;
  localparam logic [31:0] WIRE = 32'h0000_0FFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] irq = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0] grp;
  logic [2:0] ded;
  logic wake;

  int total = 0;
  int bad = 0;
  logic [31:0] en_m = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  l2_irq_aggregator #(
    .LINES(32), .NUM_GROUP(2), .GROUP_MAP({MAP1, MAP0}), .NUM_MUXED(3),
    .MUX_LINES({5'd2, 5'd1, 5'd0}), .FWD_MASK(FWD), .WAKE_EN(1'b1)
  ) dut (
    .clk(clk), .rst(rst), .irq_i(irq), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .grp_irq_o(grp), .ded_irq_o(ded), .wake_o(wake)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_of(logic [31:0] i);
    return i & WIRE & ~FWD;
  endfunction
  function automatic logic [1:0] grp_of(logic [31:0] i, logic [31:0] e);
    return {|(stat_of(i) & e & MAP1), |(stat_of(i) & e & MAP0)};
  endfunction
  function automatic logic [2:0] ded_of(logic [31:0] i, logic [31:0] e);
    return {i[2] & e[2], i[1], i[0]};
  endfunction

  task automatic write_en(logic [31:0] v, logic [2:0] a);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr = 1'b0;
    if (a[2] == 1'b0) en_m = v & WIRE;
  endtask

  task automatic read_reg(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic hold_irq(logic [31:0] v);
    @(negedge clk);
    irq = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    // Reset state
    repeat (3) @(negedge clk);
    chk("R1 grp in reset", {30'd0, grp}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 grp after reset", {30'd0, grp}, 32'd0);
    chk("R1 ded after reset", {29'd0, ded}, 32'd0);
    chk("R1 wake after reset", {31'd0, wake}, 32'd0);
    read_reg(3'd0, v);
    chk("R1 enable reset value", v, 32'd0);

    // Enable readback masked to wired lines
    write_en(32'hFFFF_FFFF, 3'd0);
    read_reg(3'd0, v);
    chk("R2 enable readback", v, WIRE);

    // Status with all inputs high; write to status ignored
    hold_irq(32'hFFFF_FFFF);
    read_reg(3'd4, v);
    chk("R3 status all high", v, 32'h0000_0FFC);
    write_en(32'h0, 3'd4);
    read_reg(3'd0, v);
    chk("R3 status write ignored", v, WIRE);

    // R10 hold
    held = rdata;
    hold_irq(32'h0);
    chk("R10 rdata held", rdata, held);

    // Only unwired lines active
    hold_irq(32'hFFFF_F000);
    chk("R5 unwired grp", {30'd0, grp}, 32'd0);
    chk("R5 unwired ded", {29'd0, ded}, 32'd0);
    chk("R5 unwired wake", {31'd0, wake}, 32'd0);
    read_reg(3'd4, v);
    chk("R5 unwired status", v, 32'd0);

    // Forwarded lines with enables off
    write_en(32'h0, 3'd0);
    hold_irq(32'h0000_0007);
    chk("R6 forwarded ded", {29'd0, ded}, 32'h3);
    chk("R8 forwarded no grp", {30'd0, grp}, 32'd0);
    chk("R8 forwarded no wake", {31'd0, wake}, 32'd0);
    write_en(32'h0000_0004, 3'd0);
    hold_irq(32'h0000_0007);
    chk("R7 gated ded", {29'd0, ded}, 32'h7);
    chk("R9 wake from line 2", {31'd0, wake}, 32'd1);

    // Single line into each group
    write_en(32'h0000_0FFF, 3'd0);
    hold_irq(32'h0000_0800);
    chk("R4 group0 single", {30'd0, grp}, 32'h1);
    hold_irq(32'h0000_0100);
    chk("R4 group1 single", {30'd0, grp}, 32'h2);

    // Constrained random with one cycle latency
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      logic [1:0] eg;
      logic [2:0] ed;
      logic ew;
      @(negedge clk);
      irq = $urandom() & ((n % 3 == 0) ? 32'hFFFF_FFFF : 32'h0000_0FFF);
      if (($urandom() % 8) == 0) begin
        wr = 1'b1; addr = 3'd0; wdata = $urandom();
      end else begin
        wr = 1'b0;
      end
      eg = grp_of(irq, en_m);
      ed = ded_of(irq, en_m);
      ew = |(stat_of(irq) & en_m);
      if (wr) en_m = wdata & WIRE;
      @(negedge clk);
      wr = 1'b0;
      chk("R4 random grp", {30'd0, grp}, {30'd0, eg});
      chk("R6 R7 random ded", {29'd0, ded}, {29'd0, ed});
      chk("R9 random wake", {31'd0, wake}, {31'd0, ew});
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule